// File: doc/BRIEF.md
# GFP Core-Header Frame Delineator

This block locks onto frame boundaries in a received octet stream that carries GFP frames. It takes one octet per cycle, qualified by a valid strobe. While it has no lock it slides along the stream one octet at a time. At each position it asks whether the four most recent octets form a core header whose check word is correct. Once it finds one, it stops sliding. It then uses the length field of that header to jump to the place where the next header must start, and checks only there.

A programmable count sets how many consecutive correct headers are needed before lock is declared. Any wrong header seen during confirmation or while locked sends the search back to the octet-by-octet hunt. Each accepted header produces a one-cycle frame-start pulse together with its payload length, so the downstream logic knows where each frame begins.

The delineator has three named states:
- **Hunt** (code 0): octet-by-octet search.
- **Pre-Sync** (code 1): a candidate frame is being confirmed.
- **Sync** (code 2): locked.

Its transitions are:
- **Hunt to Pre-Sync**: the first good header is found and the count is non-zero.
- **Hunt to Sync**: the first good header is found and the count is zero.
- **Pre-Sync to Pre-Sync**: a good header arrives and the run is still short of the count.
- **Pre-Sync to Sync**: the run of good headers reaches the count.
- **Pre-Sync to Hunt**: a bad header arrives.
- **Sync to Sync**: a good header arrives.
- **Sync to Hunt**: a bad header arrives.

Top module: `gfp_delin`

## Requirements
- R1: After reset, `state` is Hunt, `frame_start` is low and the pre-sync count is 1, so with no configuration write a single further good header after the first takes the block to Sync.
- R2: In Hunt, every accepted octet is a candidate last octet of a header. A good header at any octet alignment moves the block out of Hunt.
- R3: A core header is four octets: PLI high, PLI low, cHEC high, cHEC low. It is good when cHEC equals the CRC-16 of the two PLI octets, taken most significant bit first, with generator 0x1021 and zero initial value. A bad header seen in Hunt leaves the block in Hunt.
- R4: In Pre-Sync, the block enters Sync on the good header that makes the number of consecutive good headers seen in Pre-Sync equal to the pre-sync count N.
- R5: A bad header at the expected position in Pre-Sync returns the block to Hunt.
- R6: A bad header at the expected position in Sync returns the block to Hunt, and the consecutive-good count restarts from zero, so a full run of N is needed again.
- R7: Outside Hunt, the next header is expected to end exactly PLI+4 accepted octets after the last octet of the current header; PLI may be 0. Octets in between are ignored, even when they form a good header.
- R8: Every good header pulses `frame_start` for one cycle, in the cycle after its last octet is accepted, with `frame_len` equal to its PLI. At that moment `state` is Pre-Sync or Sync.
- R9: With a pre-sync count of 0, the first good header found in Hunt moves the block straight to Sync.
- R10: A cycle with `in_valid` low changes neither the state nor the header alignment, and produces no pulse.
- R11: `state` is encoded Hunt=0, Pre-Sync=1, Sync=2. A cycle with `cfg_wr` high loads `cfg_presync` as the new pre-sync count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Octet strobe |
| in_byte | input | 8 | Received octet |
| cfg_wr | input | 1 | Load strobe for the pre-sync count |
| cfg_presync | input | 4 | New pre-sync count |
| state | output | 2 | Delineation state (0 Hunt, 1 Pre-Sync, 2 Sync) |
| frame_start | output | 1 | One-cycle pulse per accepted header |
| frame_len | output | 16 | PLI of the header last accepted |

## Verification
The hardest case to reach from the ports is a header-shaped octet group hidden in a payload while the block waits for the next expected header. Only exact length tracking keeps the block from treating that group as a frame. The stimulus embeds a valid header inside a payload during Pre-Sync and expects no pulse from it. It also inserts idle cycles with changing octet values inside a payload, and sends zero-length frames whose headers follow back to back. A further sequence fails a header in Sync and then reacquires lock with a larger count, which shows that the good-header run started again from zero.

// File: rtl/gfp_delin_pkg.sv
package gfp_delin_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_PRESYNC = 2'd1,
        ST_SYNC    = 2'd2
    } dl_state_e;

    localparam int OCTET_BITS  = 8;
    localparam int HDR_OCTETS  = 4;
    localparam int PLI_BITS    = 2 * OCTET_BITS;
    localparam logic [15:0] HEC_GEN = 16'h1021;

    // CRC-16 over a 16-bit word, MSB first, zero seed
    function automatic logic [15:0] hec16(input logic [15:0] word);
        logic [15:0] crc;
        logic        fb;
        crc = '0;
        for (int i = 15; i >= 0; i--) begin
            fb  = crc[15] ^ word[i];
            crc = {crc[14:0], 1'b0};
            if (fb) crc = crc ^ HEC_GEN;
        end
        return crc;
    endfunction

endpackage

// File: rtl/gfp_hdr_window.sv
module gfp_hdr_window
    import gfp_delin_pkg::*;
#(
    parameter int OCT_W   = OCTET_BITS,
    parameter int N_OCT   = HDR_OCTETS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [OCT_W-1:0]       in_byte,
    output logic [2*OCT_W-1:0]     cand_pli,
    output logic                   cand_ok
);
    localparam int KEEP   = N_OCT - 1;
    localparam int HALF_W = 2 * OCT_W;

    logic [OCT_W-1:0] hist_q [KEEP];
    logic [OCT_W-1:0] cand   [N_OCT];
    logic [HALF_W-1:0] cand_hec;

    // shift register of the most recent octets
    generate
        for (genvar g = 0; g < KEEP; g++) begin : g_hist
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist_q[g] <= '0;
                end else if (in_valid) begin
                    if (g == KEEP - 1) hist_q[g] <= in_byte;
                    else               hist_q[g] <= hist_q[g+1];
                end
            end
            assign cand[g] = hist_q[g];
        end
    endgenerate

    assign cand[N_OCT-1] = in_byte;

    always_comb begin
        cand_pli = {cand[0], cand[1]};
        cand_hec = {cand[2], cand[3]};
        cand_ok  = (hec16(cand_pli) == cand_hec);
    end

endmodule

// File: rtl/gfp_skip_ctr.sv
module gfp_skip_ctr #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             hdr_due
);
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (in_valid && remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign hdr_due = (remain_q == CNT_W'(1));

endmodule

// File: rtl/gfp_delin_fsm.sv
module gfp_delin_fsm
    import gfp_delin_pkg::*;
#(
    parameter int RUN_W = 4,
    parameter int LEN_W = PLI_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             hdr_due,
    input  logic             cand_ok,
    input  logic [LEN_W-1:0] cand_pli,
    input  logic [RUN_W-1:0] presync_n,
    output dl_state_e        state,
    output logic             hdr_pass,
    output logic             frame_start,
    output logic [LEN_W-1:0] frame_len
);
    dl_state_e        state_q, state_d;
    logic [RUN_W-1:0] good_q, good_d;
    logic [RUN_W:0]   good_inc;
    logic             at_hdr, chk, pass, fail;

    always_comb begin
        at_hdr   = (state_q == ST_HUNT) || hdr_due;
        chk      = in_valid && at_hdr;
        pass     = chk && cand_ok;
        fail     = chk && !cand_ok && (state_q != ST_HUNT);
        good_inc = {1'b0, good_q} + 1'b1;
        state_d  = state_q;
        good_d   = good_q;
        unique case (state_q)
            ST_HUNT: begin
                if (pass) begin
                    good_d  = '0;
                    state_d = (presync_n == '0) ? ST_SYNC : ST_PRESYNC;
                end
            end
            ST_PRESYNC: begin
                if (fail) begin
                    good_d  = '0;
                    state_d = ST_HUNT;
                end else if (pass) begin
                    if (good_inc >= {1'b0, presync_n}) begin
                        good_d  = '0;
                        state_d = ST_SYNC;
                    end else begin
                        good_d  = good_inc[RUN_W-1:0];
                    end
                end
            end
            ST_SYNC: begin
                if (fail) begin
                    good_d  = '0;
                    state_d = ST_HUNT;
                end
            end
            default: begin
                good_d  = '0;
                state_d = ST_HUNT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            good_q  <= '0;
        end else begin
            state_q <= state_d;
            good_q  <= good_d;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_start <= 1'b0;
            frame_len   <= '0;
        end else begin
            frame_start <= pass;
            if (pass) frame_len <= cand_pli;
        end
    end

    assign state    = state_q;
    assign hdr_pass = pass;

endmodule

// File: rtl/gfp_delin.sv
module gfp_delin
    import gfp_delin_pkg::*;
#(
    parameter int          OCT_W       = OCTET_BITS,
    parameter int          RUN_W       = 4,
    parameter int          RUN_RST     = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [OCT_W-1:0]   in_byte,
    input  logic               cfg_wr,
    input  logic [RUN_W-1:0]   cfg_presync,
    output logic [1:0]         state,
    output logic               frame_start,
    output logic [2*OCT_W-1:0] frame_len
);
    localparam int LEN_W = 2 * OCT_W;
    localparam int CNT_W = LEN_W + 1;

    logic [RUN_W-1:0] presync_q;
    logic [LEN_W-1:0] cand_pli;
    logic             cand_ok;
    logic             hdr_due;
    logic             hdr_pass;
    logic [CNT_W-1:0] skip_val;
    dl_state_e        state_e;

    always_ff @(posedge clk) begin
        if (!rst_n)      presync_q <= RUN_W'(RUN_RST);
        else if (cfg_wr) presync_q <= cfg_presync;
    end

    assign skip_val = {1'b0, cand_pli} + CNT_W'(HDR_OCTETS);

    gfp_hdr_window #(.OCT_W(OCT_W), .N_OCT(HDR_OCTETS)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .cand_pli (cand_pli),
        .cand_ok  (cand_ok)
    );

    gfp_skip_ctr #(.CNT_W(CNT_W)) u_skip (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .load     (hdr_pass),
        .load_val (skip_val),
        .hdr_due  (hdr_due)
    );

    gfp_delin_fsm #(.RUN_W(RUN_W), .LEN_W(LEN_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .hdr_due     (hdr_due),
        .cand_ok     (cand_ok),
        .cand_pli    (cand_pli),
        .presync_n   (presync_q),
        .state       (state_e),
        .hdr_pass    (hdr_pass),
        .frame_start (frame_start),
        .frame_len   (frame_len)
    );

    assign state = state_e;

endmodule

// File: rtl/gfp_delin_chk.sv
module gfp_delin_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] state,
    input logic       frame_start
);
    AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'd3); // R11

    AST_PULSE_OUTSIDE_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> state != 2'd0); // R8

    AST_HUNT_EXIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'd0 && $past(state) == 2'd0) |-> frame_start); // R2

    AST_SYNC_ENTRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2 && $past(state) != 2'd2) |-> frame_start); // R4

    AST_FALLBACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd0 && $past(state) != 2'd0) |-> !frame_start); // R5

    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(state) && !frame_start)); // R10

endmodule

bind gfp_delin gfp_delin_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .state       (state),
    .frame_start (frame_start)
);

// File: tb/test_gfp_delin.sv
`timescale 1ns/1ps
module test_gfp_delin;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_presync = '0;
    logic [1:0]  state;
    logic        frame_start;
    logic [15:0] frame_len;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [15:0] exp_q [$];

    localparam logic [1:0] HUNT = 2'd0, PRE = 2'd1, SYN = 2'd2;

    always #2.5 clk = ~clk;

    gfp_delin i_gfp_delin (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .cfg_wr(cfg_wr), .cfg_presync(cfg_presync),
        .state(state), .frame_start(frame_start), .frame_len(frame_len)
    );

    function automatic logic [15:0] ref_hec(input logic [15:0] w);
        logic [15:0] c = '0;
        for (int i = 15; i >= 0; i--) begin
            if (c[15] ^ w[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
            else              c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: pop expected headers as pulses appear
    always @(negedge clk) begin
        if (rst_n && frame_start) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R7/R8: unexpected frame_start len %0d, expected none", frame_len);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (frame_len !== e) begin
                    n_fail++;
                    $display("FAIL R8: frame_len actual %0d expected %0d", frame_len, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_hdr(input logic [15:0] pli, input bit good, input bit expect_pass);
        logic [15:0] h;
        h = ref_hec(pli) ^ (good ? 16'h0000 : 16'h0100);
        send_byte(pli[15:8]);
        send_byte(pli[7:0]);
        send_byte(h[15:8]);
        if (expect_pass) exp_q.push_back(pli);
        send_byte(h[7:0]);
    endtask

    task automatic send_payload(input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) send_byte(seed ^ 8'(i * 37));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            in_byte  = 8'(8'h5A + i);
            @(negedge clk);
        end
    endtask

    task automatic set_count(input logic [3:0] v);
        cfg_wr = 1'b1;
        cfg_presync = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        logic [15:0] fake;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(state, HUNT, "R1 reset state");
        check(frame_start, 0, "R1 reset pulse");

        // default count of 1, hunt at odd alignment
        send_payload(3, 8'h12);
        check(state, HUNT, "R3 garbage stays in hunt");
        send_hdr(16'd5, 1, 1);
        check(state, PRE, "R2 hunt exit to pre-sync");
        // payload of 5 hides a valid header (R7)
        fake = 16'd9;
        send_byte(fake[15:8]); send_byte(fake[7:0]);
        send_byte(ref_hec(fake) >> 8); send_byte(ref_hec(fake) & 16'hFF);
        send_byte(8'h77);
        check(state, PRE, "R7 embedded header ignored");
        send_hdr(16'd3, 1, 1);
        check(state, SYN, "R1 R4 default count reaches sync");
        send_payload(3, 8'hC3);
        send_hdr(16'd0, 1, 1);
        send_hdr(16'd2, 1, 1);
        check(state, SYN, "R7 zero length back to back");
        send_payload(2, 8'h3C);
        send_hdr(16'd4, 0, 0);
        check(state, HUNT, "R6 bad header in sync");
        check(exp_q.size(), 0, "R8 all headers pulsed");

        // count of 3
        set_count(4'd3);
        send_payload(2, 8'h91);
        send_hdr(16'd4, 1, 1);
        check(state, PRE, "R11 hunt exit with count 3");
        send_payload(4, 8'hE1);
        send_hdr(16'd1, 1, 1);
        check(state, PRE, "R4 one of three");
        idle(3);
        check(state, PRE, "R10 idle keeps state");
        send_payload(1, 8'h4D);
        send_hdr(16'd6, 1, 1);
        check(state, PRE, "R4 R10 two of three after gap");
        send_payload(6, 8'h2B);
        send_hdr(16'd2, 1, 1);
        check(state, SYN, "R4 three of three");
        send_payload(2, 8'h66);
        send_hdr(16'd8, 0, 0);
        check(state, HUNT, "R6 fallback from sync");
        send_hdr(16'd3, 1, 1);
        send_payload(3, 8'hA4);
        send_hdr(16'd3, 1, 1);
        send_payload(3, 8'hB5);
        send_hdr(16'd3, 1, 1);
        check(state, PRE, "R6 run restarted from zero");
        send_payload(3, 8'hD7);
        send_hdr(16'd3, 1, 1);
        check(state, SYN, "R6 full run regains sync");

        // fallback from pre-sync
        send_payload(3, 8'h18);
        send_hdr(16'd1, 0, 0);
        check(state, HUNT, "R6 fallback again");
        send_hdr(16'd2, 1, 1);
        check(state, PRE, "R2 back to pre-sync");
        send_payload(2, 8'h29);
        send_hdr(16'd2, 0, 0);
        check(state, HUNT, "R5 bad header in pre-sync");
        send_hdr(16'd7, 0, 0);
        check(state, HUNT, "R3 bad header in hunt");

        // count of 0
        set_count(4'd0);
        send_hdr(16'd1, 1, 1);
        check(state, SYN, "R9 direct to sync");
        idle(2);
        check(exp_q.size(), 0, "R8 no missing pulses");
        report();
    end

endmodule